// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of a serial sigma-delta converter whose one output line is both a data-ready flag and the serial data line. The controller owns the converter's active-low power-down/reset line and its serial clock. When the host enable input goes high, the controller lifts power-down and waits a programmable settle count. After that it watches the synchronised shared line for a low level. It confirms that the low level is still present one half clock period later, then clocks out one result frame and hands the fields to the host on parallel buses with a one-cycle valid strobe.

The converter keeps converting once it is powered. After each frame the controller waits for the line to go high again and then re-arms for the next falling level, with no host command. Each frame carries a 16-bit result, most significant bit first, followed by 8 status bits. An optional pause of a parameterised length can be inserted after every 8 bits. A result that is never acknowledged before the next one arrives sets a sticky overrun flag.

The sequencer has these states. S_PWRDN holds the converter in power-down. S_SETTLE counts out the settle interval. S_WAIT_HIGH waits for the line to return high after a read. S_WAIT_LOW waits for the ready level. S_QUAL confirms that level for one half period. S_CLK_LO and S_CLK_HI are the two halves of each serial clock bit. S_PAUSE is the gap after every 8 bits. S_DONE publishes the result.

The transitions are as follows:
- S_PWRDN goes to S_SETTLE when enable is high.
- S_SETTLE goes to S_WAIT_LOW when the settle count has run out.
- S_WAIT_HIGH goes to S_WAIT_LOW when the line is high.
- S_WAIT_LOW goes to S_QUAL when the line is low.
- S_QUAL goes back to S_WAIT_LOW if the line goes high (abandon). It goes to S_CLK_LO when the half period ends with the line still low.
- S_CLK_LO goes to S_CLK_HI, and the data bit is sampled on that edge.
- S_CLK_HI goes to S_CLK_LO after an ordinary bit, to S_PAUSE after every 8th bit when a pause is configured, and to S_DONE after the 24th bit.
- S_PAUSE goes to S_CLK_LO.
- S_DONE goes to S_WAIT_HIGH.
- Any state goes to S_PWRDN when enable is low or reset is high.

Top module: `adc_readout_ctrl`

## Requirements
- R1: While rst is high, and on the first cycle after it, conv_pwr_n is 0, conv_sclk is 1, res_valid is 0 and res_overrun is 0.
- R2: A frame is 24 bits, most significant bit first. res_data gets the first 16 bits (bit 15 is the first bit received) and res_status gets the last 8 (bit 7 is the 17th bit received).
- R3: A low level on dr_line that goes high again before the half-period confirmation ends starts no serial clock. The controller then waits for the next low level.
- R4: One cycle after enable is sampled low, conv_pwr_n is 0 and conv_sclk is 1. While enable stays low, dr_line activity produces no serial clock and no res_valid. When enable returns high, readout starts again from the settle interval.
- R5: After conv_pwr_n rises, no serial clock falling edge occurs until at least SETTLE_CYCLES system cycles have passed, even if dr_line is already low.
- R6: conv_sclk idles high. Each bit has a low phase of CLK_DIV cycles and a high phase of CLK_DIV cycles. The data bit is sampled on the rising edge.
- R7: With PAUSE_CYCLES greater than 0, the high phase after the 8th and the 16th bits lasts CLK_DIV + PAUSE_CYCLES cycles. Within a byte the clock runs without gaps.
- R8: Each finished frame gives exactly one res_valid pulse, one cycle wide, with res_data and res_status valid in that cycle. The controller re-arms by itself, so every later result is read with no host action.
- R9: res_overrun is set when a new res_valid pulse is issued while the previous result has not been acknowledged with res_ack. It stays set until rst. A result that was acknowledged does not set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Host enable: high powers the converter up, low powers it down |
| dr_line | input | 1 | Shared data-ready / serial data line from the converter |
| conv_pwr_n | output | 1 | Converter power-down/reset, active low |
| conv_sclk | output | 1 | Serial clock to the converter, idles high |
| res_data | output | DATA_W | Conversion result of the last frame |
| res_status | output | STAT_W | Status byte of the last frame |
| res_valid | output | 1 | One-cycle strobe: a new result is on the buses |
| res_ack | input | 1 | Host acknowledges the current result |
| res_overrun | output | 1 | Sticky flag: a result was overwritten before it was acknowledged |

## Verification
The main readout is driven with frames of all zeros and all ones, which test the line holding its ready level through the whole frame. Alternating and walking-bit frames catch shift-order, byte-swap and off-by-one-bit faults between the data and status fields. Each frame's clock edges are timestamped, which separates a correct pause placement from a pause after the wrong bit or a shortened phase. Directed runs cover a short low glitch (abandoned read), a ready level held through the settle interval, power-down in the middle of a frame with the line toggling, and unacknowledged back-to-back results.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [3:0] {
        S_PWRDN,
        S_SETTLE,
        S_WAIT_HIGH,
        S_WAIT_LOW,
        S_QUAL,
        S_CLK_LO,
        S_CLK_HI,
        S_PAUSE,
        S_DONE
    } rd_state_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RESET_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RESET_VAL;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst)           word <= '0;
        else if (shift_en) word <= {word[W-2:0], din};
    end
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int STAT_W        = 8,
    parameter int BYTE_BITS     = 8,
    parameter int CLK_DIV       = 4,
    parameter int PAUSE_CYCLES  = 0,
    parameter int SETTLE_CYCLES = 250000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              dr_line,
    output logic              conv_pwr_n,
    output logic              conv_sclk,
    output logic [DATA_W-1:0] res_data,
    output logic [STAT_W-1:0] res_status,
    output logic              res_valid,
    input  logic              res_ack,
    output logic              res_overrun
);
    localparam int FRAME_W    = DATA_W + STAT_W;
    localparam int BW         = $clog2(FRAME_W);
    localparam int TMAX       = max3(SETTLE_CYCLES, CLK_DIV, PAUSE_CYCLES);
    localparam int TW         = $clog2(TMAX + 1);
    localparam int PAUSE_LOAD = (PAUSE_CYCLES > 0) ? PAUSE_CYCLES - 1 : 0;
    localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE_CYCLES - 1);
    localparam logic [TW-1:0] T_HALF   = TW'(CLK_DIV - 1);
    localparam logic [TW-1:0] T_PAUSE  = TW'(PAUSE_LOAD);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

    rd_state_t    st, st_nx;
    logic         rdy_s;
    logic         t_load, t_exp;
    logic [TW-1:0] t_val;
    logic         sh_en;
    logic         bit_clr, bit_inc;
    logic [BW-1:0] bit_cnt;
    logic [FRAME_W-1:0] frame_word;
    logic         frame_done;
    logic         last_bit, byte_end;
    logic         pending;

    adc_rd_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d(dr_line), .q(rdy_s)
    );

    adc_rd_timer #(.W(TW)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_exp)
    );

    adc_rd_shifter #(.W(FRAME_W)) u_shift (
        .clk(clk), .rst(rst), .shift_en(sh_en), .din(rdy_s), .word(frame_word)
    );

    // Bit position within the frame
    always_ff @(posedge clk) begin
        if (rst || bit_clr) bit_cnt <= '0;
        else if (bit_inc)   bit_cnt <= bit_cnt + 1'b1;
    end

    assign last_bit = (bit_cnt == LAST_BIT);
    assign byte_end = ((int'(bit_cnt) % BYTE_BITS) == BYTE_BITS - 1);

    // State register
    always_ff @(posedge clk) begin
        if (rst) st <= S_PWRDN;
        else     st <= st_nx;
    end

    // Next state and timer / shifter control
    always_comb begin
        st_nx   = st;
        t_load  = 1'b0;
        t_val   = T_HALF;
        sh_en   = 1'b0;
        bit_clr = 1'b0;
        bit_inc = 1'b0;
        unique case (st)
            S_PWRDN: begin
                if (enable) begin
                    st_nx  = S_SETTLE;
                    t_load = 1'b1;
                    t_val  = T_SETTLE;
                end
            end
            S_SETTLE: begin
                if (t_exp) st_nx = S_WAIT_LOW;
            end
            S_WAIT_HIGH: begin
                if (rdy_s) st_nx = S_WAIT_LOW;
            end
            S_WAIT_LOW: begin
                if (!rdy_s) begin
                    st_nx  = S_QUAL;
                    t_load = 1'b1;
                end
            end
            S_QUAL: begin
                if (rdy_s) begin
                    st_nx = S_WAIT_LOW;
                end else if (t_exp) begin
                    st_nx   = S_CLK_LO;
                    t_load  = 1'b1;
                    bit_clr = 1'b1;
                end
            end
            S_CLK_LO: begin
                if (t_exp) begin
                    st_nx  = S_CLK_HI;
                    t_load = 1'b1;
                    sh_en  = 1'b1;
                end
            end
            S_CLK_HI: begin
                if (t_exp) begin
                    bit_inc = 1'b1;
                    if (last_bit) begin
                        st_nx = S_DONE;
                    end else if (PAUSE_CYCLES > 0 && byte_end) begin
                        st_nx  = S_PAUSE;
                        t_load = 1'b1;
                        t_val  = T_PAUSE;
                    end else begin
                        st_nx  = S_CLK_LO;
                        t_load = 1'b1;
                    end
                end
            end
            S_PAUSE: begin
                if (t_exp) begin
                    st_nx  = S_CLK_LO;
                    t_load = 1'b1;
                end
            end
            S_DONE: begin
                st_nx = S_WAIT_HIGH;
            end
            default: st_nx = S_PWRDN;
        endcase
        if (!enable) st_nx = S_PWRDN;
    end

    // Outputs decoded from the state
    always_comb begin
        conv_pwr_n = (st != S_PWRDN);
        conv_sclk  = (st != S_CLK_LO);
        frame_done = (st == S_DONE);
    end

    // Result hold registers, strobe and overrun tracking
    always_ff @(posedge clk) begin
        if (rst) begin
            res_data    <= '0;
            res_status  <= '0;
            res_valid   <= 1'b0;
            pending     <= 1'b0;
            res_overrun <= 1'b0;
        end else begin
            res_valid <= frame_done;
            if (frame_done) begin
                res_data   <= frame_word[FRAME_W-1 -: DATA_W];
                res_status <= frame_word[STAT_W-1:0];
                if (pending && !res_ack) res_overrun <= 1'b1;
                pending <= 1'b1;
            end else if (res_ack) begin
                pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_readout_ctrl_chk.sv
module adc_readout_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic conv_pwr_n,
    input logic conv_sclk,
    input logic res_valid,
    input logic res_overrun
);
    // R4
    pwrdn_follows_enable_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !conv_pwr_n);

    // R4
    sclk_idle_in_pwrdn_chk: assert property (@(posedge clk) disable iff (rst)
        !conv_pwr_n |-> conv_sclk);

    // R8
    valid_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        res_overrun |=> res_overrun);

    // R9
    overrun_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(res_overrun) |-> res_valid);
endmodule

bind adc_readout_ctrl adc_readout_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .enable(enable), .conv_pwr_n(conv_pwr_n),
    .conv_sclk(conv_sclk), .res_valid(res_valid), .res_overrun(res_overrun)
);

// File: tb/adc_readout_ctrl_tb_top.sv
module adc_readout_ctrl_tb_top;
    localparam int DIV    = 4;
    localparam int PAUSE  = 10;
    localparam int SETTLE = 200;
    localparam int NVEC   = 6;
    localparam logic [23:0] VEC [NVEC] = '{
        24'hA5C33C, 24'h000000, 24'hFFFFFF, 24'h8001_01, 24'h5AAA_55, 24'h1234_F0
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic dr_line = 1'b1;
    logic res_ack = 1'b0;
    logic conv_pwr_n, conv_sclk, res_valid, res_overrun;
    logic [15:0] res_data;
    logic [7:0]  res_status;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int falls = 0;
    int vcnt = 0;
    int tf [24];
    int tr [24];
    int t_en;

    always #2 clk = ~clk;

    adc_readout_ctrl #(
        .CLK_DIV(DIV), .PAUSE_CYCLES(PAUSE), .SETTLE_CYCLES(SETTLE)
    ) dut_i (
        .clk(clk), .rst(rst), .enable(enable), .dr_line(dr_line),
        .conv_pwr_n(conv_pwr_n), .conv_sclk(conv_sclk),
        .res_data(res_data), .res_status(res_status), .res_valid(res_valid),
        .res_ack(res_ack), .res_overrun(res_overrun)
    );

    always @(posedge clk) cyc++;
    always @(negedge conv_sclk) falls++;
    always @(posedge clk) if (res_valid) vcnt++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Converter model: one frame, then checks of result, strobe and clock shape
    task automatic run_frame(input logic [23:0] f, input bit do_ack, input bit exp_ovr);
        bit got;
        bit shape_ok;
        bit pause_ok;
        got = 1'b0;
        @(negedge clk) dr_line = 1'b0;
        for (int i = 0; i < 24; i++) begin
            @(negedge conv_sclk);
            tf[i] = cyc;
            dr_line = f[23-i];
            @(posedge conv_sclk);
            tr[i] = cyc;
        end
        dr_line = 1'b1;
        for (int k = 0; k < 400 && !got; k++) begin
            @(negedge clk);
            if (res_valid) got = 1'b1;
        end
        chk(got, "R8", "valid strobe seen", int'(got), 1);
        chk(res_data == f[23:8], "R2", "data field", int'(res_data), int'(f[23:8]));
        chk(res_status == f[7:0], "R2", "status field", int'(res_status), int'(f[7:0]));
        chk(res_overrun == exp_ovr, "R9", "overrun flag", int'(res_overrun), int'(exp_ovr));
        res_ack = do_ack;
        @(negedge clk);
        res_ack = 1'b0;
        chk(!res_valid, "R8", "valid one cycle wide", int'(res_valid), 0);
        shape_ok = 1'b1;
        pause_ok = 1'b1;
        for (int i = 0; i < 24; i++) begin
            if (tr[i] - tf[i] != DIV) shape_ok = 1'b0;
            if (i < 23) begin
                if (i == 7 || i == 15) begin
                    if (tf[i+1] - tr[i] != DIV + PAUSE) pause_ok = 1'b0;
                end else if (tf[i+1] - tr[i] != DIV) begin
                    shape_ok = 1'b0;
                end
            end
        end
        chk(shape_ok, "R6", "bit phase lengths", int'(shape_ok), 1);
        chk(pause_ok, "R7", "byte pause lengths", int'(pause_ok), 1);
    endtask

    initial begin
        int f0, v0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(conv_pwr_n == 1'b0, "R1", "pwr_n in reset", int'(conv_pwr_n), 0);
        chk(conv_sclk == 1'b1, "R1", "sclk in reset", int'(conv_sclk), 1);
        chk(res_valid == 1'b0, "R1", "valid in reset", int'(res_valid), 0);
        chk(res_overrun == 1'b0, "R1", "overrun in reset", int'(res_overrun), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(conv_pwr_n == 1'b0, "R1", "pwr_n after reset", int'(conv_pwr_n), 0);

        // R5 settle: line low early, no clock before the settle count ends
        enable = 1'b1;
        t_en = cyc;
        @(negedge clk);
        chk(conv_pwr_n == 1'b1, "R5", "pwr_n released", int'(conv_pwr_n), 1);
        repeat (SETTLE / 2) @(negedge clk);
        dr_line = 1'b0;
        repeat (SETTLE / 2 - 10) @(negedge clk);
        chk(falls == 0, "R5", "no clock during settle", falls, 0);
        run_frame(VEC[0], 1'b1, 1'b0);
        chk(tf[0] - t_en >= SETTLE, "R5", "first fall after settle", tf[0] - t_en, SETTLE);

        // Table walk: R8 re-arm without host commands
        v0 = vcnt;
        for (int v = 1; v < NVEC; v++) begin
            repeat (5) @(negedge clk);
            run_frame(VEC[v], 1'b1, 1'b0);
        end
        chk(vcnt - v0 == NVEC - 1, "R8", "one strobe per frame", vcnt - v0, NVEC - 1);

        // R3 glitch shorter than the confirmation: abandoned
        repeat (10) @(negedge clk);
        f0 = falls;
        dr_line = 1'b0;
        repeat (2) @(negedge clk);
        dr_line = 1'b1;
        repeat (60) @(negedge clk);
        chk(falls == f0, "R3", "glitch starts no clock", falls - f0, 0);
        run_frame(24'h3C5A_81, 1'b1, 1'b0);

        // R4 power-down in the middle of a frame
        repeat (10) @(negedge clk);
        f0 = falls;
        dr_line = 1'b0;
        wait (falls >= f0 + 5);
        @(negedge clk) enable = 1'b0;
        @(negedge clk);
        chk(conv_pwr_n == 1'b0, "R4", "pwr_n after disable", int'(conv_pwr_n), 0);
        chk(conv_sclk == 1'b1, "R4", "sclk after disable", int'(conv_sclk), 1);
        f0 = falls;
        v0 = vcnt;
        for (int k = 0; k < 10; k++) begin
            dr_line = ~dr_line;
            repeat (10) @(negedge clk);
        end
        dr_line = 1'b1;
        chk(falls == f0, "R4", "no clock while down", falls - f0, 0);
        chk(vcnt == v0, "R4", "no strobe while down", vcnt - v0, 0);
        enable = 1'b1;
        repeat (2) @(negedge clk);
        run_frame(24'hC0DE_7E, 1'b1, 1'b0);

        // R9 overrun: two results without acknowledge
        repeat (5) @(negedge clk);
        run_frame(24'h1111_11, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        run_frame(24'h2222_22, 1'b0, 1'b1);
        repeat (5) @(negedge clk);
        run_frame(24'h3333_33, 1'b1, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(res_overrun == 1'b0, "R9", "overrun cleared by reset", int'(res_overrun), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule